// File: doc/BRIEF.md
# Truncated Exponential Backoff Timer

This block times the wait a station makes after a collision on a shared medium before it tries to transmit the frame again. A one-cycle start pulse carries the retransmission attempt number n. On that pulse the block takes a pseudo-random count r of slot times from a free-running 16-bit maximal-length LFSR. It then counts r slots of `SLOT_BITS` bit times each, advancing only on a bit-time strobe. When the count runs out it raises `done` and holds it high.

The upper bound on r grows with n and stops growing at n = `K_MAX` (default 10). A mode input chooses how busy traffic is handled. In normal mode every strobe counts. In deferring mode the counters freeze while receive carrier sense is high, so backoff lasts longer on a busy channel. The drawn count is driven on an output port so that surrounding logic, or a bench, can see the wait it should expect.

Top module: `backoff_timer`

## Requirements
- R1: After reset, `done` is 0 and `slots_drawn` is 0.
- R2: On a start pulse with attempt number n, `slots_drawn` takes, from the next cycle on, a value r with 0 <= r < 2^min(n, K_MAX). An attempt number of 0 gives r = 0.
- R3: With r > 0, `done` rises at the clock edge that consumes the (r x SLOT_BITS)-th counted strobe after the start edge. A strobe in the start cycle itself is not counted.
- R4: With r = 0, `done` is 1 from the clock edge of the start pulse.
- R5: With `defer_mode` = 0, `carrier` has no effect: every strobe after the start edge is counted.
- R6: With `defer_mode` = 1, a strobe in a cycle where `carrier` = 1 is not counted, and counting resumes once `carrier` falls.
- R7: A start pulse that arrives while a count is running discards that count, draws again from the new attempt number, and restarts the timing from that edge.
- R8: `done` stays 1 until the next start pulse. That pulse clears it unless its own draw is 0.
- R9: Start pulses repeated with the same attempt number do not always produce the same draw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a backoff |
| attempt | input | N_W | Retransmission attempt number n, sampled with start |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| defer_mode | input | 1 | 1 selects freezing the count while carrier is sensed |
| carrier | input | 1 | Receive carrier sense |
| slots_drawn | output | K_MAX | Slot count r drawn at the last start |
| done | output | 1 | Backoff interval has elapsed |

## Verification
A wrong slot or bit counter shows up as `done` rising early, late or never, measured against r times the slot length in counted strobes. A reference model that is compared every cycle catches this on the exact cycle of the mismatch. A wrong mask shows up as a `slots_drawn` outside its range in the cycle after start. Mishandling of carrier in either mode moves the rise of `done` by the number of strobes that were wrongly counted or wrongly skipped. A restart that does not reload shows up as a stale `done` or a stale rise time right after the second pulse.

// File: rtl/backoff_timer.sv
module backoff_timer #(
  parameter int SLOT_BITS = 512,
  parameter int K_MAX     = 10,
  parameter int N_W       = 5,
  parameter int LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N_W-1:0]   attempt,
  input  logic             bit_tick,
  input  logic             defer_mode,
  input  logic             carrier,
  output logic [K_MAX-1:0] slots_drawn,
  output logic             done
);
  localparam int BW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

  logic [LFSR_W-1:0] lfsr;
  logic [K_MAX-1:0]  slots_left, mask, draw_now;
  logic [BW-1:0]     bit_cnt;
  logic [N_W-1:0]    k;
  logic              busy, cnt_en, slot_end;

  assign k        = (attempt > N_W'(K_MAX)) ? N_W'(K_MAX) : attempt;
  assign mask     = ~({K_MAX{1'b1}} << k);
  assign draw_now = lfsr[K_MAX-1:0] & mask;
  assign cnt_en   = busy && bit_tick && !(defer_mode && carrier);
  assign slot_end = bit_cnt == BW'(SLOT_BITS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr        <= LFSR_W'(1);
      slots_drawn <= '0;
      slots_left  <= '0;
      bit_cnt     <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_TAPS : '0);
      if (start) begin
        slots_drawn <= draw_now;
        slots_left  <= draw_now;
        bit_cnt     <= '0;
        busy        <= draw_now != '0;
        done        <= draw_now == '0;
      end else if (cnt_en) begin
        if (slot_end) begin
          bit_cnt    <= '0;
          slots_left <= slots_left - 1'b1;
          if (slots_left == K_MAX'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  a_r2_draw_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (slots_drawn & ~$past(mask)) == '0);
  a_r4_zero_draw_done: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (done == (slots_drawn == '0)));
  a_r6_freeze_on_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && defer_mode && carrier) |=> $stable(bit_cnt) && $stable(slots_left));
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  a_r3_done_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !$past(start)) |-> $past(bit_tick));
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slots_left != '0 && !done));
endmodule

// File: tb/test_backoff_timer.sv
module test_backoff_timer;
  localparam int SB = 8;
  localparam int KM = 10;
  logic clk = 0, rst_n = 0, start = 0, bit_tick = 0, defer_mode = 0, carrier = 0;
  logic [4:0] attempt = 0;
  logic [KM-1:0] slots_drawn;
  logic done;
  int vectors = 0, errors = 0;
  string tag = "R1";
  int tick_period = 1, crs_period = 0;

  always #10 clk = ~clk;

  backoff_timer #(.SLOT_BITS(SB), .K_MAX(KM)) i_backoff_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .attempt(attempt), .bit_tick(bit_tick),
    .defer_mode(defer_mode), .carrier(carrier), .slots_drawn(slots_drawn), .done(done));

  int m_left = 0, m_k = 0;
  bit m_loaded = 0, m_pend = 0;
  int first_draw = -1;
  bit seen_diff = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_loaded = 0; m_pend = 0;
    end else if (start) begin
      m_pend = 1; m_loaded = 0;
      m_k = (attempt > KM) ? KM : int'(attempt);
    end else if (m_loaded && m_left > 0 && bit_tick && !(defer_mode && carrier)) begin
      m_left--;
    end
  end

  function automatic void check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_pend) begin
        m_pend = 0; m_loaded = 1;
        m_left = int'(slots_drawn) * SB;
        check(int'(slots_drawn) < (1 << m_k), "R2", int'(slots_drawn), (1 << m_k) - 1);
        if (m_k == KM) begin
          if (first_draw < 0) first_draw = int'(slots_drawn);
          else if (first_draw != int'(slots_drawn)) seen_diff = 1;
        end
      end
      check(done == (m_loaded && m_left == 0), tag, int'(done), int'(m_loaded && m_left == 0));
    end
  end

  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    bit_tick <= (tick_period > 0) && (cyc % tick_period == 0);
    carrier  <= (crs_period > 0) && ((cyc / crs_period) % 2 == 1);
  end

  task automatic pulse(input int n);
    @(negedge clk); start = 1; attempt = 5'(n);
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim && !done; i++) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 0, "R1", int'(done), 0);
    check(slots_drawn == 0, "R1", int'(slots_drawn), 0);
    rst_n = 1;
    tag = "R4"; pulse(0);
    check(done == 1, "R4", int'(done), 1);
    repeat (5) @(negedge clk);
    tag = "R3";
    for (int n = 1; n <= 12; n++) begin pulse(n); wait_done(20000); repeat (3) @(negedge clk); end
    tag = "R5"; crs_period = 5; tick_period = 2;
    for (int n = 3; n <= 8; n++) begin pulse(n); wait_done(20000); end
    tag = "R6"; defer_mode = 1; crs_period = 7; tick_period = 1;
    for (int n = 2; n <= 9; n++) begin pulse(n); wait_done(30000); end
    tag = "R7"; crs_period = 0;
    pulse(10); repeat (30) @(negedge clk);
    pulse(6); repeat (10) @(negedge clk);
    pulse(10); wait_done(20000);
    tag = "R8"; repeat (100) @(negedge clk);
    check(done == 1, "R8", int'(done), 1);
    pulse(4); wait_done(2000);
    tag = "R9"; defer_mode = 0;
    for (int i = 0; i < 6; i++) begin pulse(10); repeat (40) @(negedge clk); end
    check(seen_diff, "R9", int'(seen_diff), 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule